// File: doc/BRIEF.md
# Shared-Datapath Integer ALU

This block is the combinational 32-bit integer ALU of a small pipelined core. It evaluates one register or immediate operation per cycle from two operands and a three-bit operation field plus a seven-bit high function field. It also produces the three comparison flags that the branch unit needs: equal, signed less-than and unsigned less-than. It holds no state. The result and the flags settle in the same cycle in which the operands are presented.

The datapath is built for low area. It has exactly one adder, one left shifter and one bitwise unit.
- Subtraction is done on the adder as A + ~B + 1.
- Both set-less-than operations and every branch compare take their answer from that single subtraction. There is no separate magnitude comparator.
- Logical right shift has no shifter of its own. The operand is bit-reversed, passed through the left shifter, and the output is reversed again.

A compare-request input lets the branch unit force the adder to subtract, whatever operation field is presented.

Top module: `lean_alu`

## Requirements
- R1: With `imm_form`=0, `cmp_req`=0 and `op_f3`=000, the result is A+B when `op_hi` is 0000000 and A-B (modulo 2^32) when `op_hi` is 1000000.
- R2: With `imm_form`=1 and `op_f3`=000, the result is A+B for every value of `op_hi`, including 1000000.
- R3: `op_f3`=001 gives A shifted left by B[4:0], with zero fill. B[31:5] and `op_hi` have no effect on the result.
- R4: `op_f3`=101 gives A shifted right logically by B[4:0], with zero fill from the top. B[31:5] and `op_hi` have no effect on the result.
- R5: `op_f3`=010 gives 1 in bit 0 when A is less than B as two's-complement numbers, and 0 otherwise. Bits 31..1 of the result are zero.
- R6: `op_f3`=011 gives 1 in bit 0 when A is less than B as unsigned numbers, and 0 otherwise. Bits 31..1 of the result are zero.
- R7: `op_f3`=100 gives A xor B, 110 gives A or B, and 111 gives A and B.
- R8: Whenever the adder subtracts, `flag_eq` is 1 exactly when A equals B. The adder subtracts when `cmp_req`=1, when `op_f3` is 010 or 011, or in the subtract case of R1.
- R9: Whenever the adder subtracts, `flag_lt` is 1 exactly when A is less than B as signed numbers, including when the operand signs differ.
- R10: Whenever the adder subtracts, `flag_ltu` is 1 exactly when A is less than B as unsigned numbers.
- R11: `cmp_req`=1 forces subtraction. With `op_f3`=000 the result is then A-B, even when `imm_form`=1 or `op_hi`=0000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, or the immediate, or the shift amount in bits 4..0 |
| op_f3 | input | 3 | Operation field |
| op_hi | input | 7 | High function field; 1000000 selects subtract in register form |
| imm_form | input | 1 | 1 for immediate-form instructions |
| cmp_req | input | 1 | 1 forces the adder to subtract, for branch compares |
| result | output | 32 | Operation result |
| flag_eq | output | 1 | A equals B (valid while subtracting) |
| flag_lt | output | 1 | A less than B, signed (valid while subtracting) |
| flag_ltu | output | 1 | A less than B, unsigned (valid while subtracting) |

## Verification
The block has no registers, so a fault in its decode or datapath shows at the ports in the same cycle as the stimulus. Because one adder is shared, a wrong subtract select or a wrong carry sense shows up together in the arithmetic result, in a set-less-than bit and in a branch flag. Operands whose signs differ expose a missing correction in the signed flag. A broken bit in the reversal wiring shows on a right shift as a moved or missing bit for every non-zero shift amount.

// File: rtl/lean_alu_pkg.sv
package lean_alu_pkg;

  typedef enum logic [2:0] {
    F3_ADDSUB = 3'b000,
    F3_SHL    = 3'b001,
    F3_LTS    = 3'b010,
    F3_LTU    = 3'b011,
    F3_XOR    = 3'b100,
    F3_SHR    = 3'b101,
    F3_OR     = 3'b110,
    F3_AND    = 3'b111
  } f3_e;

  typedef enum logic [1:0] {
    LOP_XOR = 2'd0,
    LOP_OR  = 2'd1,
    LOP_AND = 2'd2
  } lop_e;

  typedef enum logic [1:0] {
    SEL_SUM   = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_LOGIC = 2'd2,
    SEL_LESS  = 2'd3
  } rsel_e;

  typedef struct packed {
    logic  sub;
    logic  shift_rev;
    logic  less_signed;
    lop_e  lop;
    rsel_e rsel;
  } alu_ctl_t;

  localparam logic [6:0] HI_SUB = 7'b1000000;

  // Operation decode; kept as a function so intent reads as one table.
  function automatic alu_ctl_t decode_op(input logic [2:0] f3,
                                         input logic [6:0] hi,
                                         input logic       imm,
                                         input logic       cmp);
    alu_ctl_t c;
    c.sub         = cmp;
    c.shift_rev   = 1'b0;
    c.less_signed = 1'b0;
    c.lop         = LOP_XOR;
    c.rsel        = SEL_SUM;
    case (f3)
      F3_ADDSUB: begin
        c.rsel = SEL_SUM;
        if (!imm && hi == HI_SUB) c.sub = 1'b1;
      end
      F3_SHL: c.rsel = SEL_SHIFT;
      F3_SHR: begin
        c.rsel      = SEL_SHIFT;
        c.shift_rev = 1'b1;
      end
      F3_LTS: begin
        c.rsel        = SEL_LESS;
        c.sub         = 1'b1;
        c.less_signed = 1'b1;
      end
      F3_LTU: begin
        c.rsel = SEL_LESS;
        c.sub  = 1'b1;
      end
      F3_XOR: begin
        c.rsel = SEL_LOGIC;
        c.lop  = LOP_XOR;
      end
      F3_OR: begin
        c.rsel = SEL_LOGIC;
        c.lop  = LOP_OR;
      end
      default: begin
        c.rsel = SEL_LOGIC;
        c.lop  = LOP_AND;
      end
    endcase
    return c;
  endfunction

  // Signed less-than from the difference sign, corrected when the operand signs differ.
  function automatic logic signed_less(input logic a_msb,
                                       input logic b_msb,
                                       input logic diff_msb);
    return (a_msb != b_msb) ? a_msb : diff_msb;
  endfunction

endpackage

// File: rtl/lean_alu_decode.sv
module lean_alu_decode
  import lean_alu_pkg::*;
(
  input  logic [2:0] f3,
  input  logic [6:0] hi,
  input  logic       imm,
  input  logic       cmp,
  output alu_ctl_t   ctl
);

  always_comb ctl = decode_op(f3, hi, imm, cmp);

  // A shift never selects the adder's subtract path unless a compare is forced.
  always_comb begin
    if (!cmp && (f3 == F3_SHL || f3 == F3_SHR))
      AST_SHIFT_NO_SUB: assert (!ctl.sub); // R3
  end

  // Immediate add is never turned into a subtract.
  always_comb begin
    if (imm && !cmp && f3 == F3_ADDSUB)
      AST_IMM_ADDS: assert (!ctl.sub); // R2
  end

endmodule

// File: rtl/lean_alu_adder.sv
module lean_alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int WX = W + 1;

  logic [W-1:0]  b_eff;
  logic [WX-1:0] full;

  always_comb begin
    b_eff = b ^ {W{sub}};
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  end

  assign sum  = full[W-1:0];
  assign cout = full[W];

  // While subtracting, carry-out set means no borrow: A >= B unsigned.
  always_comb begin
    if (sub) AST_BORROW_SENSE: assert (cout == (a >= b)); // R10
  end

endmodule

// File: rtl/lean_alu_lshift.sv
module lean_alu_lshift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          rev,
  output logic [W-1:0]  dout
);

  logic [W-1:0] din_r;
  logic [W-1:0] pre;
  logic [W-1:0] shl;
  logic [W-1:0] shl_r;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign din_r[i] = din[W-1-i];
    assign shl_r[i] = shl[W-1-i];
  end

  always_comb begin
    pre  = rev ? din_r : din;
    shl  = pre << amt;
    dout = rev ? shl_r : shl;
  end

  always_comb begin
    if (amt == '0) AST_SHIFT_ZERO_IDENT: assert (dout == din); // R3
  end

  always_comb begin
    if (rev && amt != '0) AST_SHR_ZERO_FILL: assert (dout[W-1] == 1'b0); // R4
  end

  always_comb begin
    if (!rev && amt != '0) AST_SHL_ZERO_FILL: assert (dout[0] == 1'b0); // R3
  end

endmodule

// File: rtl/lean_alu_logic.sv
module lean_alu_logic
  import lean_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  lop_e         lop,
  output logic [W-1:0] y
);

  always_comb begin
    case (lop)
      LOP_OR:  y = a | b;
      LOP_AND: y = a & b;
      default: y = a ^ b;
    endcase
  end

endmodule

// File: rtl/lean_alu.sv
module lean_alu
  import lean_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   op_f3,
  input  logic [6:0]   op_hi,
  input  logic         imm_form,
  input  logic         cmp_req,
  output logic [W-1:0] result,
  output logic         flag_eq,
  output logic         flag_lt,
  output logic         flag_ltu
);

  alu_ctl_t     ctl;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] sh_out;
  logic [W-1:0] lg_out;
  logic         less_bit;
  logic [W-1:0] less_word;
  logic         sub_active;

  lean_alu_decode u_dec (
    .f3  (op_f3),
    .hi  (op_hi),
    .imm (imm_form),
    .cmp (cmp_req),
    .ctl (ctl)
  );

  lean_alu_adder #(.W(W)) u_add (
    .a    (opnd_a),
    .b    (opnd_b),
    .sub  (ctl.sub),
    .sum  (add_sum),
    .cout (add_cout)
  );

  lean_alu_lshift #(.W(W), .SW(SW)) u_sh (
    .din  (opnd_a),
    .amt  (opnd_b[SW-1:0]),
    .rev  (ctl.shift_rev),
    .dout (sh_out)
  );

  lean_alu_logic #(.W(W)) u_lg (
    .a   (opnd_a),
    .b   (opnd_b),
    .lop (ctl.lop),
    .y   (lg_out)
  );

  assign sub_active = ctl.sub;

  always_comb begin
    flag_eq   = ~|add_sum;
    flag_ltu  = ~add_cout;
    flag_lt   = signed_less(opnd_a[W-1], opnd_b[W-1], add_sum[W-1]);
    less_bit  = ctl.less_signed ? flag_lt : flag_ltu;
    less_word = {{(W-1){1'b0}}, less_bit};
  end

  always_comb begin
    case (ctl.rsel)
      SEL_SHIFT: result = sh_out;
      SEL_LOGIC: result = lg_out;
      SEL_LESS:  result = less_word;
      default:   result = add_sum;
    endcase
  end

  always_comb begin
    if (sub_active) AST_EQ_FLAG: assert (flag_eq == (opnd_a == opnd_b)); // R8
  end

  always_comb begin
    if (sub_active) AST_LT_FLAG: assert (flag_lt == ($signed(opnd_a) < $signed(opnd_b))); // R9
  end

  always_comb begin
    if (sub_active) AST_LTU_FLAG: assert (flag_ltu == (opnd_a < opnd_b)); // R10
  end

  always_comb begin
    if (op_f3 == 3'b010 || op_f3 == 3'b011)
      AST_LESS_ZEXT: assert (result[W-1:1] == '0); // R5
  end

  always_comb begin
    if (cmp_req && op_f3 == 3'b000)
      AST_CMP_FORCES_SUB: assert (result == opnd_a - opnd_b); // R11
  end

endmodule

// File: tb/tb_lean_alu.sv
module tb_lean_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [2:0]  f3;
  logic [6:0]  hi;
  logic        imm, cmp;
  logic [31:0] result;
  logic        feq, flt, fltu;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lean_alu dut (
    .opnd_a(a), .opnd_b(b), .op_f3(f3), .op_hi(hi),
    .imm_form(imm), .cmp_req(cmp),
    .result(result), .flag_eq(feq), .flag_lt(flt), .flag_ltu(fltu)
  );

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h1234_5678;
      6: return 32'hDEAD_BEEF;
      default: return 32'h0000_0025;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op, input logic i, input logic c,
                                input logic [6:0] h);
    case (op)
      3'd0: return c ? "R11" : (i ? "R2" : (h == 7'h40 ? "R1(sub)" : "R1(add)"));
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd5: return "R4";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [2:0] op, input logic [6:0] h,
                                        input logic i, input logic c);
    logic s;
    s = c || (op == 3'd0 && !i && h == 7'h40);
    case (op)
      3'd0: return s ? x - y : x + y;
      3'd1: return x << y[4:0];
      3'd2: return {31'd0, $signed(x) < $signed(y)};
      3'd3: return {31'd0, x < y};
      3'd4: return x ^ y;
      3'd5: return x >> y[4:0];
      3'd6: return x | y;
      default: return x & y;
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h f3=%b hi=%b imm=%b cmp=%b got=%h exp=%h",
               r, a, b, f3, hi, imm, cmp, got, exp);
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [31:0] y, input logic [2:0] op,
                     input logic [6:0] h, input logic i, input logic c);
    logic s;
    @(posedge clk);
    a = x; b = y; f3 = op; hi = h; imm = i; cmp = c;
    @(negedge clk);
    chk(tag(op, i, c, h), result, model(x, y, op, h, i, c));
    s = c || op == 3'd2 || op == 3'd3 || (op == 3'd0 && !i && h == 7'h40);
    if (s) begin
      chk("R8",  {31'd0, feq},  {31'd0, x == y});
      chk("R9",  {31'd0, flt},  {31'd0, $signed(x) < $signed(y)});
      chk("R10", {31'd0, fltu}, {31'd0, x < y});
    end
  endtask

  initial begin
    a = '0; b = '0; f3 = '0; hi = '0; imm = 0; cmp = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle value: zero operands add to zero
    chk("R1(idle)", result, 32'd0);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int op = 0; op < 8; op++)
          run(pat(i), pat(j), 3'(op), 7'h00, 1'b0, 1'b0);
        run(pat(i), pat(j), 3'd0, 7'h40, 1'b0, 1'b0);
        run(pat(i), pat(j), 3'd0, 7'h40, 1'b1, 1'b0);
        run(pat(i), pat(j), 3'd0, 7'h00, 1'b1, 1'b1);
        run(pat(i), pat(j), 3'd4, 7'h00, 1'b0, 1'b1);
        run(pat(i), pat(j), 3'd2, 7'h40, 1'b1, 1'b0);
      end
    end

    // Shift sweep: every amount, upper B bits and op_hi set to noise (R3, R4)
    for (int s = 0; s < 32; s++) begin
      for (int k = 2; k < 7; k++) begin
        run(pat(k), 32'hA5A5_A5E0 | 32'(s), 3'd1, 7'h40, 1'b0, 1'b0);
        run(pat(k), 32'h5A5A_5A40 | 32'(s), 3'd5, 7'h7F, 1'b1, 1'b0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule